// File: doc/BRIEF.md
# Dual-Channel DMA Control Register File

This block holds the control and status words of a two-channel DMA front end. Channel 0 serves a disk-side SCSI controller and channel 1 serves a network controller. A host writes 32-bit words by byte address. The block keeps a small window of word registers and applies special rules to the two channel control words and to the channel-0 address word. The address and count datapath and the memory transfers sit outside this block.

When software writes a control word, the block acts on the attached controller. A set reset bit sends a one-cycle reset pulse to that controller. A clear interrupt-enable bit sends a one-cycle pulse that tells the controller's interrupt logic to drop its line. The top nibble of each control word never holds software data: it always reads back as a fixed hardware version code. The channel-0 control word also has a rule for bit 6. The bit clears itself when it is written as one, and a write of all zeros becomes 0x40. A write to the channel-0 address word marks the channel as loaded.

Top module: `dmactl_regs`

## Requirements
- R1: The register index is (byte address AND (NUM_REGS*4-1)) shifted right by two. With the default NUM_REGS of 8, address bits 5 and above are ignored, so address 0x128 reaches index 2.
- R2: A write to index 0 (channel-0 control) with bit 4 (interrupt enable) clear raises `scsi_irq_drop` for the cycle after the write. With bit 4 set, no pulse occurs.
- R3: A write to index 0 with bit 7 (reset) set raises `scsi_reset_pulse` for the cycle after the write.
- R4: On an index-0 write with bit 7 clear, a value with bit 6 set is stored with bit 6 cleared, and a full 32-bit value of zero is stored as 0x40. With bit 7 set, bits 27:0 are stored as written.
- R5: Reading index 0 or index 4 always returns the VERSION code (default 4'hA) in bits 31:28, whatever was written there, including straight after reset.
- R6: A write to index 1 stores the full word at index 1. It also sets bit 14 (loaded) of the channel-0 control word and leaves that word's other bits unchanged.
- R7: A write to index 4 (channel-1 control) drives `net_irq_drop` from a clear bit 4 and `net_reset_pulse` from a set bit 7, with the same timing as channel 0. Bits 27:0 are stored as written, with no bit-6 rule. It never pulses the channel-0 outputs.
- R8: A write to any other index stores and reads back all 32 bits unchanged. It raises no output pulse.
- R9: After a synchronous reset, every register reads zero except the version nibble of the two control words, and all four pulse outputs are low.
- R10: Each pulse lasts exactly one cycle. It is low again in the next cycle unless another qualifying write arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe, one word per cycle |
| wr_addr | input | ADDR_W | Byte address of the write |
| wr_data | input | 32 | Write data |
| rd_addr | input | ADDR_W | Byte address of the combinational read |
| rd_data | output | 32 | Read data |
| scsi_reset_pulse | output | 1 | One-cycle reset to the SCSI controller |
| scsi_irq_drop | output | 1 | One-cycle request to drop the SCSI interrupt |
| net_reset_pulse | output | 1 | One-cycle reset to the network controller |
| net_irq_drop | output | 1 | One-cycle request to drop the network interrupt |

## Verification
A single control write can ask for a controller reset and an interrupt drop at the same time. The bench provokes this with a channel-0 write that has bit 7 set and bit 4 clear. It checks that both channel-0 pulses rise together in the following cycle and fall together one cycle later, and that the channel-1 outputs stay low. The same write also carries bit 6, so the bench confirms that the reset bit stops the bit-6 rule. The stored word must keep bit 6.

// File: rtl/dmactl_pkg.sv
package dmactl_pkg;

    localparam int DATA_W      = 32;
    localparam int VER_W       = 4;
    localparam int CTRL_LOW_W  = DATA_W - VER_W;
    localparam int WORD_SHIFT  = 2;

    // Fixed word indices whose behaviour other logic decodes
    localparam int IDX_CH0_CTRL = 0;
    localparam int IDX_CH0_ADDR = 1;
    localparam int IDX_CH1_CTRL = 4;

    // Control word bit positions
    localparam int BIT_IEN    = 4;
    localparam int BIT_AUTO   = 6;
    localparam int BIT_RST    = 7;
    localparam int BIT_LOADED = 14;

    typedef struct packed {
        logic rst_pulse;
        logic irq_drop;
    } chan_evt_t;

    typedef logic [CTRL_LOW_W-1:0] ctrl_low_t;

    // Value stored for a control write; the version nibble is never stored.
    function automatic ctrl_low_t shape_ctrl(input logic [DATA_W-1:0] v,
                                             input logic auto_rule);
        ctrl_low_t r;
        r = v[CTRL_LOW_W-1:0];
        if (auto_rule && !v[BIT_RST]) begin
            if (v[BIT_AUTO])
                r[BIT_AUTO] = 1'b0;
            else if (v == '0)
                r[BIT_AUTO] = 1'b1;
        end
        return r;
    endfunction

endpackage

// File: rtl/dmactl_decode.sv
module dmactl_decode
    import dmactl_pkg::*;
#(
    parameter int ADDR_W   = 12,
    parameter int NUM_REGS = 8
) (
    input  logic                      wr_en,
    input  logic [ADDR_W-1:0]         wr_addr,
    input  logic [ADDR_W-1:0]         rd_addr,
    output logic [NUM_REGS-1:0]       wr_sel,
    output logic [$clog2(NUM_REGS)-1:0] rd_idx
);
    localparam int IDX_W     = $clog2(NUM_REGS);
    localparam int WIN_BYTES = NUM_REGS << WORD_SHIFT;

    logic [ADDR_W-1:0] wr_masked;
    logic [ADDR_W-1:0] rd_masked;
    logic [IDX_W-1:0]  wr_idx;

    always_comb begin
        wr_masked = wr_addr & ADDR_W'(WIN_BYTES - 1);
        rd_masked = rd_addr & ADDR_W'(WIN_BYTES - 1);
        wr_idx    = IDX_W'(wr_masked >> WORD_SHIFT);
        rd_idx    = IDX_W'(rd_masked >> WORD_SHIFT);
    end

    for (genvar k = 0; k < NUM_REGS; k++) begin : g_sel
        assign wr_sel[k] = wr_en && (wr_idx == IDX_W'(k));
    end

endmodule

// File: rtl/dmactl_ctrl_chan.sv
module dmactl_ctrl_chan
    import dmactl_pkg::*;
#(
    parameter bit AUTO_RULE = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic [DATA_W-1:0] data,
    input  logic              load_set,
    output ctrl_low_t         low_q,
    output chan_evt_t         evt_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            low_q <= '0;
            evt_q <= '0;
        end else begin
            evt_q <= '0;
            if (wr) begin
                low_q           <= shape_ctrl(data, AUTO_RULE);
                evt_q.rst_pulse <= data[BIT_RST];
                evt_q.irq_drop  <= ~data[BIT_IEN];
            end else if (load_set) begin
                low_q[BIT_LOADED] <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/dmactl_store.sv
module dmactl_store
    import dmactl_pkg::*;
#(
    parameter int                NUM_REGS  = 8,
    parameter logic [NUM_REGS-1:0] SKIP_MASK = '0
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic [NUM_REGS-1:0]              sel,
    input  logic [DATA_W-1:0]                data,
    output logic [NUM_REGS-1:0][DATA_W-1:0]  q
);

    for (genvar k = 0; k < NUM_REGS; k++) begin : g_word
        if (SKIP_MASK[k]) begin : g_skip
            assign q[k] = '0;
        end else begin : g_keep
            always_ff @(posedge clk) begin
                if (rst)
                    q[k] <= '0;
                else if (sel[k])
                    q[k] <= data;
            end
        end
    end

endmodule

// File: rtl/dmactl_regs.sv
module dmactl_regs
    import dmactl_pkg::*;
#(
    parameter int         ADDR_W   = 12,
    parameter int         NUM_REGS = 8,
    parameter logic [3:0] VERSION  = 4'hA
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [31:0]       wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [31:0]       rd_data,
    output logic              scsi_reset_pulse,
    output logic              scsi_irq_drop,
    output logic              net_reset_pulse,
    output logic              net_irq_drop
);
    localparam int IDX_W = $clog2(NUM_REGS);
    localparam int NUM_CH = 2;
    localparam logic [NUM_REGS-1:0] CTRL_MASK =
        (NUM_REGS'(1) << IDX_CH0_CTRL) | (NUM_REGS'(1) << IDX_CH1_CTRL);

    logic [NUM_REGS-1:0]             wr_sel;
    logic [IDX_W-1:0]                rd_idx;
    logic [NUM_REGS-1:0][DATA_W-1:0] plain_q;
    ctrl_low_t                       ch_low [NUM_CH];
    chan_evt_t                       ch_evt [NUM_CH];

    dmactl_decode #(
        .ADDR_W   (ADDR_W),
        .NUM_REGS (NUM_REGS)
    ) u_decode (
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .rd_addr (rd_addr),
        .wr_sel  (wr_sel),
        .rd_idx  (rd_idx)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
        localparam int CIDX = (c == 0) ? IDX_CH0_CTRL : IDX_CH1_CTRL;
        logic load_hook;
        if (c == 0) begin : g_load
            assign load_hook = wr_sel[IDX_CH0_ADDR];
        end else begin : g_noload
            assign load_hook = 1'b0;
        end
        dmactl_ctrl_chan #(
            .AUTO_RULE (c == 0)
        ) u_chan (
            .clk      (clk),
            .rst      (rst),
            .wr       (wr_sel[CIDX]),
            .data     (wr_data),
            .load_set (load_hook),
            .low_q    (ch_low[c]),
            .evt_q    (ch_evt[c])
        );
    end

    dmactl_store #(
        .NUM_REGS  (NUM_REGS),
        .SKIP_MASK (CTRL_MASK)
    ) u_store (
        .clk  (clk),
        .rst  (rst),
        .sel  (wr_sel),
        .data (wr_data),
        .q    (plain_q)
    );

    always_comb begin
        if (rd_idx == IDX_W'(IDX_CH0_CTRL))
            rd_data = {VERSION, ch_low[0]};
        else if (rd_idx == IDX_W'(IDX_CH1_CTRL))
            rd_data = {VERSION, ch_low[1]};
        else
            rd_data = plain_q[rd_idx];
    end

    assign scsi_reset_pulse = ch_evt[0].rst_pulse;
    assign scsi_irq_drop    = ch_evt[0].irq_drop;
    assign net_reset_pulse  = ch_evt[1].rst_pulse;
    assign net_irq_drop     = ch_evt[1].irq_drop;

endmodule

// File: rtl/dmactl_chk.sv
module dmactl_chk
    import dmactl_pkg::*;
#(
    parameter int         ADDR_W   = 12,
    parameter int         NUM_REGS = 8,
    parameter logic [3:0] VERSION  = 4'hA
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [31:0]       wr_data,
    input logic [ADDR_W-1:0] rd_addr,
    input logic [31:0]       rd_data,
    input logic              scsi_reset_pulse,
    input logic              scsi_irq_drop,
    input logic              net_reset_pulse,
    input logic              net_irq_drop,
    input ctrl_low_t         ch0_low
);
    localparam int IDX_W = $clog2(NUM_REGS);

    logic [IDX_W-1:0] w_idx;
    logic [IDX_W-1:0] r_idx;
    assign w_idx = wr_addr[IDX_W+1:2];
    assign r_idx = rd_addr[IDX_W+1:2];

    logic w0, w1, w4;
    assign w0 = wr_en && (w_idx == IDX_W'(IDX_CH0_CTRL));
    assign w1 = wr_en && (w_idx == IDX_W'(IDX_CH0_ADDR));
    assign w4 = wr_en && (w_idx == IDX_W'(IDX_CH1_CTRL));

    // R3
    scsi_rst_src_chk: assert property (@(posedge clk) disable iff (rst)
        scsi_reset_pulse |-> $past(w0 && wr_data[BIT_RST]));

    // R2
    scsi_drop_src_chk: assert property (@(posedge clk) disable iff (rst)
        scsi_irq_drop |-> $past(w0 && !wr_data[BIT_IEN]));

    // R7
    net_rst_src_chk: assert property (@(posedge clk) disable iff (rst)
        net_reset_pulse |-> $past(w4 && wr_data[BIT_RST]));

    // R7
    net_drop_src_chk: assert property (@(posedge clk) disable iff (rst)
        net_irq_drop |-> $past(w4 && !wr_data[BIT_IEN]));

    // R5
    version_chk: assert property (@(posedge clk) disable iff (rst)
        (r_idx == IDX_W'(IDX_CH0_CTRL) || r_idx == IDX_W'(IDX_CH1_CTRL))
            |-> rd_data[31:28] == VERSION);

    // R6
    loaded_chk: assert property (@(posedge clk) disable iff (rst)
        w1 |=> ch0_low[BIT_LOADED]);

    // R4
    auto_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (w0 && !wr_data[BIT_RST] && wr_data[BIT_AUTO]) |=> !ch0_low[BIT_AUTO]);

    // R8
    plain_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !w0 && !w4) |=> !(scsi_reset_pulse || scsi_irq_drop
                                   || net_reset_pulse || net_irq_drop));

endmodule

bind dmactl_regs dmactl_chk #(
    .ADDR_W   (ADDR_W),
    .NUM_REGS (NUM_REGS),
    .VERSION  (VERSION)
) u_chk (
    .clk              (clk),
    .rst              (rst),
    .wr_en            (wr_en),
    .wr_addr          (wr_addr),
    .wr_data          (wr_data),
    .rd_addr          (rd_addr),
    .rd_data          (rd_data),
    .scsi_reset_pulse (scsi_reset_pulse),
    .scsi_irq_drop    (scsi_irq_drop),
    .net_reset_pulse  (net_reset_pulse),
    .net_irq_drop     (net_irq_drop),
    .ch0_low          (ch_low[0])
);

// File: tb/dmactl_regs_bench.sv
`timescale 1ns/1ps
module dmactl_regs_bench;
    localparam int ADDR_W = 12;
    localparam logic [3:0] VER = 4'hA;
    localparam logic [31:0] VTOP = {VER, 28'h0};

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              wr_en = 1'b0;
    logic [ADDR_W-1:0] wr_addr = '0;
    logic [31:0]       wr_data = '0;
    logic [ADDR_W-1:0] rd_addr = '0;
    logic [31:0]       rd_data;
    logic              scsi_reset_pulse, scsi_irq_drop, net_reset_pulse, net_irq_drop;

    int n_cmp = 0;
    int n_bad = 0;
    logic [3:0] evt;   // {scsi_rst, scsi_drop, net_rst, net_drop} in the cycle after a write

    always #2 clk = ~clk;

    dmactl_regs #(.ADDR_W(ADDR_W), .NUM_REGS(8), .VERSION(VER)) u_dmactl_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data),
        .scsi_reset_pulse(scsi_reset_pulse), .scsi_irq_drop(scsi_irq_drop),
        .net_reset_pulse(net_reset_pulse), .net_irq_drop(net_irq_drop)
    );

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
        end
    endtask

    function automatic logic [3:0] pulses();
        return {scsi_reset_pulse, scsi_irq_drop, net_reset_pulse, net_irq_drop};
    endfunction

    task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        evt = pulses();
    endtask

    task automatic rd_chk(input string req, input logic [ADDR_W-1:0] a, input logic [31:0] exp);
        rd_addr = a;
        #0.5;
        check(req, rd_data, exp);
    endtask

    task automatic idle_chk(input string req);
        @(negedge clk);
        check(req, 32'(pulses()), 32'h0);
    endtask

    task automatic t_reset();
        for (int k = 0; k < 8; k++)
            rd_chk("R9 reset value", ADDR_W'(k * 4), (k == 0 || k == 4) ? VTOP : 32'h0);
        check("R9 pulses low after reset", 32'(pulses()), 32'h0);
    endtask

    task automatic t_plain();
        wr(12'h008, 32'hDEADBEEF);
        check("R8 no pulse on plain write", 32'(evt), 32'h0);
        rd_chk("R8 idx2", 12'h008, 32'hDEADBEEF);
        wr(12'h00C, 32'hF0F0_0001);
        wr(12'h014, 32'h1234_5678);
        wr(12'h018, 32'h0000_0040);
        wr(12'h01C, 32'hFFFF_FFFF);
        rd_chk("R8 idx3", 12'h00C, 32'hF0F0_0001);
        rd_chk("R8 idx5", 12'h014, 32'h1234_5678);
        rd_chk("R8 idx6 bit6 kept", 12'h018, 32'h0000_0040);
        rd_chk("R8 idx7", 12'h01C, 32'hFFFF_FFFF);
        wr(12'h128, 32'hCAFE_0002);
        rd_chk("R1 upper address bits ignored (write)", 12'h008, 32'hCAFE_0002);
        rd_chk("R1 upper address bits ignored (read)", 12'hF28, 32'hCAFE_0002);
    endtask

    task automatic t_ch0_auto();
        wr(12'h000, 32'h0000_0050);
        check("R2 no drop with enable set", 32'(evt), 32'h0);
        rd_chk("R4 bit6 cleared", 12'h000, VTOP | 32'h10);
        wr(12'h000, 32'h0);
        check("R2 drop pulse on enable clear", 32'(evt), 32'b0100);
        rd_chk("R4 zero stored as 0x40", 12'h000, VTOP | 32'h40);
        idle_chk("R10 drop pulse falls");
        wr(12'h000, 32'hF000_0011);
        rd_chk("R5 version replaces top nibble", 12'h000, VTOP | 32'h11);
        wr(12'h000, 32'hF000_0000);
        rd_chk("R4 nonzero top only is not zero", 12'h000, VTOP);
    endtask

    task automatic t_ch0_reset_and_drop();
        wr(12'h000, 32'h0000_00C0);
        check("R3 reset and drop together", 32'(evt), 32'b1100);
        rd_chk("R4 reset bit blocks bit6 rule", 12'h000, VTOP | 32'hC0);
        idle_chk("R10 both pulses fall");
    endtask

    task automatic t_loaded();
        wr(12'h000, 32'h0000_0010);
        wr(12'h004, 32'h1234_5678);
        rd_chk("R6 address word stored", 12'h004, 32'h1234_5678);
        rd_chk("R6 loaded bit set", 12'h000, VTOP | 32'h4010);
    endtask

    task automatic t_ch1();
        wr(12'h010, 32'h0000_0040);
        check("R7 net drop only", 32'(evt), 32'b0001);
        rd_chk("R7 bit6 kept", 12'h010, VTOP | 32'h40);
        wr(12'h010, 32'h0);
        rd_chk("R7 zero stays zero", 12'h010, VTOP);
        wr(12'h010, 32'h5000_0090);
        check("R7 net reset, no drop", 32'(evt), 32'b0010);
        rd_chk("R7 version forced", 12'h010, VTOP | 32'h90);
        idle_chk("R10 net pulse falls");
        rd_chk("R7 channel 0 untouched", 12'h000, VTOP | 32'h4010);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_plain();
        t_ch0_auto();
        t_ch0_reset_and_drop();
        t_loaded();
        t_ch1();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule